// File: doc/BRIEF.md
# Four-Way True LRU Order Tracker

This block keeps the exact recency order of the four ways of one cache set. The order is not stored as per-way age counters. It is stored as six pairwise "newer than" bits, one for each unordered pair of ways. Each reference pulse names a way, and that way becomes the most recently used. The block always reports which way is least recently used. It also reports whether the six stored bits describe a consistent ordering.

The six-bit code has 64 possible values. Only 24 of them are consistent orderings, one for each permutation of the four ways. The remaining 40 values hold a cycle such as "1 newer than 0, 2 newer than 1, 0 newer than 2", so no single ordering matches them. A cache controller drives one reference pulse per hit or fill on the set and reads the victim way from the LRU output. The tag store and the hit detection belong to the surrounding cache and are not part of this block.

The block has three states, all of them transitions of the six-bit code register. The reset state loads all ones, which is the ascending order with way 0 oldest and way 3 newest. The reference transition rewrites only the three pair bits that involve the named way. The hold transition, taken on any cycle without a reference, keeps the code unchanged.

Top module: `lru4_order_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, `victim_way` is 0 and `order_ok` is 1. The code register loads all ones, which is the ascending order 0,1,2,3 with way 0 oldest.
- R2: Pair bit encoding, with bit = hi*(hi-1)/2 + lo for lo < hi: bit0 = way1 newer than way0, bit1 = way2 newer than way0, bit2 = way2 newer than way1, bit3 = way3 newer than way0, bit4 = way3 newer than way1, bit5 = way3 newer than way2. A reference to way k sets every pair bit where k is the higher index, clears every pair bit where k is the lower index, and leaves the other bits unchanged. After the reference, way k is never reported as the victim.
- R3: After every clock edge, `victim_way` equals the way referenced longest ago. A way that has not been referenced since reset is older than any referenced way, and such ways are ordered by ascending index.
- R4: On a clock edge with `hit_valid` low, the order does not change, whatever value `hit_way` has.
- R5: After reset, `order_ok` stays 1 for any sequence of references.
- R6: A reference to a way that is not the current victim leaves `victim_way` unchanged.
- R7: A reference to the current victim moves `victim_way` to the next-oldest way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | Reference pulse for the way named by `hit_way` |
| hit_way | input | 2 | Way index being referenced |
| victim_way | output | 2 | Least recently used way |
| order_ok | output | 1 | High when the stored code is one of the 24 consistent orderings |

## Verification
The bench drives long random streams of references and idle cycles against an ordered-list model of recency. This catches a design that flips the sense of one pair bit or swaps two bit positions: the reported victim would drift away from the list within a few references. Directed sequences reference the current victim over and over, so the victim must move through every way. They also reference the newest way repeatedly, which must leave the victim unchanged. A design that rewrote a pair bit not involving the referenced way would fail both checks and would also drop `order_ok`. Idle cycles carry a changing `hit_way`, so a design that let the way index leak through without the pulse would be seen.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
    // Position of the pair bit meaning "way hi is newer than way lo", lo < hi.
    function automatic int pair_index(input int lo, input int hi);
        return (hi * (hi - 1)) / 2 + lo;
    endfunction
endpackage

// File: rtl/lru4_next_code.sv
module lru4_next_code #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int PAIR_W  = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
    input  logic [PAIR_W-1:0] code_cur,
    input  logic              hit_valid,
    input  logic [WAY_W-1:0]  hit_way,
    output logic [PAIR_W-1:0] code_nxt
);
    import lru4_pkg::*;

    for (genvar hi = 1; hi < NUM_WAYS; hi++) begin : g_hi
        for (genvar lo = 0; lo < hi; lo++) begin : g_lo
            localparam int               BIT   = pair_index(lo, hi);
            localparam logic [WAY_W-1:0] HI_ID = WAY_W'(hi);
            localparam logic [WAY_W-1:0] LO_ID = WAY_W'(lo);
            always_comb begin
                if (hit_valid && hit_way == HI_ID)
                    code_nxt[BIT] = 1'b1;
                else if (hit_valid && hit_way == LO_ID)
                    code_nxt[BIT] = 1'b0;
                else
                    code_nxt[BIT] = code_cur[BIT];
            end
        end
    end
endmodule

// File: rtl/lru4_rank_decode.sv
module lru4_rank_decode #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int PAIR_W  = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
    input  logic [PAIR_W-1:0] code_cur,
    output logic [WAY_W-1:0]  oldest_way,
    output logic              code_consistent
);
    import lru4_pkg::*;

    logic [WAY_W-1:0]    rank [NUM_WAYS];
    logic [NUM_WAYS-1:0] rank_seen;

    // Rank of a way = number of other ways it is newer than.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            rank[w] = '0;
            for (int v = 0; v < NUM_WAYS; v++) begin
                if (v < w && code_cur[pair_index(v, w)])
                    rank[w] = rank[w] + WAY_W'(1);
                else if (v > w && !code_cur[pair_index(w, v)])
                    rank[w] = rank[w] + WAY_W'(1);
            end
        end
    end

    // Consistent iff the ranks form a permutation of 0..NUM_WAYS-1.
    always_comb begin
        rank_seen = '0;
        for (int w = 0; w < NUM_WAYS; w++)
            rank_seen[rank[w]] = 1'b1;
        code_consistent = &rank_seen;
    end

    // Lowest-index way of rank zero.
    always_comb begin
        oldest_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--)
            if (rank[w] == '0)
                oldest_way = WAY_W'(w);
    end
endmodule

// File: rtl/lru4_order_tracker.sv
module lru4_order_tracker #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int PAIR_W  = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    output logic             order_ok
);
    // All ones: every higher way newer than every lower way (0 oldest).
    localparam logic [PAIR_W-1:0] CODE_RESET = '1;

    logic [PAIR_W-1:0] code_q;
    logic [PAIR_W-1:0] code_d;
    logic [WAY_W-1:0]  oldest;
    logic              consistent;

    lru4_next_code #(.NUM_WAYS(NUM_WAYS)) i_next (
        .code_cur  (code_q),
        .hit_valid (hit_valid),
        .hit_way   (hit_way),
        .code_nxt  (code_d)
    );

    lru4_rank_decode #(.NUM_WAYS(NUM_WAYS)) i_rank (
        .code_cur        (code_q),
        .oldest_way      (oldest),
        .code_consistent (consistent)
    );

    // State register: reset state, then reference or hold transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_q <= CODE_RESET;
        else
            code_q <= code_d;
    end

    // Outputs.
    always_comb begin
        victim_way = oldest;
        order_ok   = consistent;
    end
endmodule

// File: rtl/lru4_order_checker.sv
module lru4_order_checker #(
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_valid,
    input logic [WAY_W-1:0] hit_way,
    input logic [WAY_W-1:0] victim_way,
    input logic             order_ok
);
    AST_RESET_ORDER: assert property (@(posedge clk) !rst_n |=> (victim_way == '0 && order_ok)); // R1

    AST_REF_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> victim_way != $past(hit_way)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> $stable(victim_way)); // R4

    AST_ORDER_OK: assert property (@(posedge clk) disable iff (!rst_n)
        order_ok); // R5

    AST_OTHER_KEEPS_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_way != victim_way) |=> $stable(victim_way)); // R6

    AST_VICTIM_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_way == victim_way) |=> !$stable(victim_way)); // R7
endmodule

bind lru4_order_tracker lru4_order_checker #(.WAY_W(WAY_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_way    (hit_way),
    .victim_way (victim_way),
    .order_ok   (order_ok)
);

// File: tb/test_lru4_order_tracker.sv
module test_lru4_order_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_way = 2'd0;
    logic [1:0] victim_way;
    logic       order_ok;

    int n_checks = 0;
    int n_fails = 0;
    int order[$];  // order[0] = oldest

    always #5 clk = ~clk;

    lru4_order_tracker i_lru4_order_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_valid  (hit_valid),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .order_ok   (order_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_ref(input int w);
        foreach (order[i]) if (order[i] == w) begin order.delete(i); break; end
        order.push_back(w);
    endtask

    // Drive one cycle, let the edge pass, then compare away from the edge.
    task automatic step(input bit v, input int w, input string req);
        @(negedge clk);
        hit_valid = v;
        hit_way   = 2'(w);
        @(posedge clk);
        #2;
        if (v) model_ref(w);
        check(req, int'(victim_way), order[0]);
        check("R5 order_ok", int'(order_ok), 1);
    endtask

    initial begin
        int prev;
        order = {0, 1, 2, 3};
        repeat (3) @(negedge clk);
        check("R1 reset victim", int'(victim_way), 0);
        check("R1 reset order_ok", int'(order_ok), 1);
        rst_n = 1'b1;
        step(1'b0, 2, "R1 first cycle after reset");

        // R7: referencing the victim walks it through 1,2,3,0
        for (int k = 0; k < 8; k++) begin
            prev = int'(victim_way);
            step(1'b1, prev, "R7 victim reference");
            check("R7 victim moved", int'(victim_way != 2'(prev)), 1);
        end
        // R6: referencing the newest way keeps the victim
        for (int k = 0; k < 4; k++) begin
            prev = int'(victim_way);
            step(1'b1, order[3], "R6 newest reference");
            check("R6 victim kept", int'(victim_way), prev);
        end
        // R4: idle cycles with a changing way index
        for (int k = 0; k < 8; k++) step(1'b0, k % 4, "R4 idle hold");
        // R2: descending order makes way 3 oldest
        for (int w = 3; w >= 0; w--) step(1'b1, w, "R2 descending");
        check("R2 way 3 oldest", int'(victim_way), 3);
        // R3: random mixed stream
        for (int k = 0; k < 3000; k++) begin
            bit v;
            int w;
            v = ($urandom % 4) != 0;
            w = int'($urandom % 4);
            step(v, w, "R3 random stream");
            if (v) check("R2 referenced not victim", int'(victim_way == 2'(w)), 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule